// File: doc/BRIEF.md
# Split-Screen Fetch Address Generator

This block produces the display-memory word address for a raster panel controller that stacks two independent memory regions vertically on one panel. The host programs an upper-region start address, a lower-region start address, a 10-bit line count for the upper region, a per-line memory stride and the number of physical panel lines, all through a byte-wide register port. A timing generator supplies three strobes: start of frame, start of line and pixel fetch.

Starting with line 0 of each frame, fetches come from the upper-region start address. The line base moves forward by the stride on every new line. When the line index reaches the programmed split count, the line base reloads from the lower-region start address and stays there until the frame ends. A flag output shows which region supplies the current fetch. Host writes go into a pending copy of the registers. The active copy loads from the pending copy only on a frame-start strobe, so a frame is never torn during its scan.

Top module: `split_fetch_addr`

## Requirements
- R1: Host register indices: 0/1 upper start low/high byte, 2/3 lower start low/high byte, 4 split count bits 7:0, 5 split count bits 9:8 in data bits 1:0, 6/7 stride low/high byte, 8/9 panel line count bits 7:0 and bits 9:8 (data bits 1:0). A read returns the last value written. Bits 7:2 of indices 5 and 9 always read zero. Any other index reads zero.
- R2: Host writes do not change fetchAddr or inScreen2, and do not change the addresses used by later line strobes, until the next frameStart.
- R3: One cycle after frameStart with a nonzero split count, fetchAddr equals the upper start address and inScreen2 is 0.
- R4: A pixFetch strobe with no frame or line strobe raises fetchAddr by one on the next cycle. A lineStart in the same cycle takes precedence over pixFetch. With no strobe, fetchAddr and inScreen2 hold their values.
- R5: On a lineStart that causes neither a split nor a wrap, fetchAddr becomes the previous line base plus the stride.
- R6: On the lineStart that makes the line index equal to the split count, fetchAddr becomes the lower start address and inScreen2 becomes 1. Later lines advance by the stride from that address.
- R7: When the line index would reach the panel line count, it wraps to line 0 and the base reloads as at frame start. If the split count is at least the panel line count, inScreen2 never becomes 1.
- R8: A split count of zero selects the lower region from line 0: after frameStart, fetchAddr equals the lower start address and inScreen2 is 1.
- R9: The upper region is always shown first, whatever the numeric order of the two start addresses. Equal start addresses need no special handling.
- R10: After reset, fetchAddr is 0, inScreen2 is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host byte write enable |
| hostIdx | input | 4 | Host register index |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for hostIdx (combinational) |
| frameStart | input | 1 | Start-of-frame strobe, also the start of line 0 |
| lineStart | input | 1 | Start-of-line strobe |
| pixFetch | input | 1 | Pixel fetch strobe |
| fetchAddr | output | 16 | Current display-memory word address |
| inScreen2 | output | 1 | 1 while the lower region is being fetched |

## Verification
The checker tests these rules on every cycle: the one-step pixel increment, holding when no strobe is present, the region chosen at frame start for zero and nonzero split counts, entry to the lower region exactly at its start address, and the zero upper bits of the high-byte registers. Only the bench scenarios can show the effects that span several lines and frames. These are stride accumulation, the split line landing on the right index, wrap at the panel height, a split count beyond the panel that never switches, reversed and equal start addresses, and host writes during a frame having no effect until the next frame start.

// File: rtl/splitscr_pkg.sv
package splitscr_pkg;
  localparam int ADDR_W = 16;
  localparam int LINE_W = 10;
  localparam int IDX_W  = 4;
  localparam int HI_W   = LINE_W - 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LINE_W-1:0] line_t;

  // strobes from line control to the address datapath
  typedef struct packed {
    logic loadBase;    // reload line base from a start address
    logic pickScr2;    // choose lower-region start address
    logic fromPending; // use pending copy (frame start)
    logic addStride;   // advance line base by stride
    logic pixStep;     // advance fetch address by one
  } fetchCmd_t;
endpackage

// File: rtl/splitscr_regs.sv
module splitscr_regs
  import splitscr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wrData,
  input  logic             frameStart,
  output logic [7:0]       rdData,
  output addr_t            scr1Pend,
  output addr_t            scr2Pend,
  output addr_t            scr1Act,
  output addr_t            scr2Act,
  output addr_t            strideAct,
  output line_t            splitPend,
  output line_t            splitAct,
  output line_t            panelAct
);
  addr_t stridePend;
  line_t panelPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scr1Pend   <= '0;
      scr2Pend   <= '0;
      stridePend <= '0;
      splitPend  <= '0;
      panelPend  <= '0;
    end else if (wrEn) begin
      case (idx)
        4'd0: scr1Pend[7:0]          <= wrData;
        4'd1: scr1Pend[15:8]         <= wrData;
        4'd2: scr2Pend[7:0]          <= wrData;
        4'd3: scr2Pend[15:8]         <= wrData;
        4'd4: splitPend[7:0]         <= wrData;
        4'd5: splitPend[LINE_W-1:8]  <= wrData[HI_W-1:0];
        4'd6: stridePend[7:0]        <= wrData;
        4'd7: stridePend[15:8]       <= wrData;
        4'd8: panelPend[7:0]         <= wrData;
        4'd9: panelPend[LINE_W-1:8]  <= wrData[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scr1Act   <= '0;
      scr2Act   <= '0;
      strideAct <= '0;
      splitAct  <= '0;
      panelAct  <= '0;
    end else if (frameStart) begin
      scr1Act   <= scr1Pend;
      scr2Act   <= scr2Pend;
      strideAct <= stridePend;
      splitAct  <= splitPend;
      panelAct  <= panelPend;
    end
  end

  always_comb begin
    case (idx)
      4'd0:    rdData = scr1Pend[7:0];
      4'd1:    rdData = scr1Pend[15:8];
      4'd2:    rdData = scr2Pend[7:0];
      4'd3:    rdData = scr2Pend[15:8];
      4'd4:    rdData = splitPend[7:0];
      4'd5:    rdData = {{(8-HI_W){1'b0}}, splitPend[LINE_W-1:8]};
      4'd6:    rdData = stridePend[7:0];
      4'd7:    rdData = stridePend[15:8];
      4'd8:    rdData = panelPend[7:0];
      4'd9:    rdData = {{(8-HI_W){1'b0}}, panelPend[LINE_W-1:8]};
      default: rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/splitscr_ctrl.sv
module splitscr_ctrl
  import splitscr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      lineStart,
  input  logic      pixFetch,
  input  line_t     splitPend,
  input  line_t     splitAct,
  input  line_t     panelAct,
  output fetchCmd_t cmd,
  output logic      inScreen2
);
  line_t lineIdx;
  line_t nextLine;
  logic  wrapHit;
  logic  splitHit;

  assign nextLine = lineIdx + 1'b1;
  assign wrapHit  = (nextLine == panelAct);
  assign splitHit = (nextLine == splitAct) && !inScreen2;

  always_comb begin
    cmd = '0;
    if (frameStart) begin
      cmd.loadBase    = 1'b1;
      cmd.fromPending = 1'b1;
      cmd.pickScr2    = (splitPend == '0);
    end else if (lineStart) begin
      if (wrapHit) begin
        cmd.loadBase = 1'b1;
        cmd.pickScr2 = (splitAct == '0);
      end else if (splitHit) begin
        cmd.loadBase = 1'b1;
        cmd.pickScr2 = 1'b1;
      end else begin
        cmd.addStride = 1'b1;
      end
    end else if (pixFetch) begin
      cmd.pixStep = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineIdx   <= '0;
      inScreen2 <= 1'b0;
    end else if (frameStart) begin
      lineIdx   <= '0;
      inScreen2 <= (splitPend == '0);
    end else if (lineStart) begin
      if (wrapHit) begin
        lineIdx   <= '0;
        inScreen2 <= (splitAct == '0);
      end else begin
        lineIdx <= nextLine;
        if (splitHit) inScreen2 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/splitscr_path.sv
module splitscr_path
  import splitscr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  fetchCmd_t cmd,
  input  addr_t     scr1Pend,
  input  addr_t     scr2Pend,
  input  addr_t     scr1Act,
  input  addr_t     scr2Act,
  input  addr_t     strideAct,
  output addr_t     fetchAddr
);
  addr_t lineBase;
  addr_t srcAddr;
  addr_t strideNext;

  always_comb begin
    if (cmd.pickScr2) srcAddr = cmd.fromPending ? scr2Pend : scr2Act;
    else              srcAddr = cmd.fromPending ? scr1Pend : scr1Act;
  end

  assign strideNext = lineBase + strideAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineBase  <= '0;
      fetchAddr <= '0;
    end else if (cmd.loadBase) begin
      lineBase  <= srcAddr;
      fetchAddr <= srcAddr;
    end else if (cmd.addStride) begin
      lineBase  <= strideNext;
      fetchAddr <= strideNext;
    end else if (cmd.pixStep) begin
      fetchAddr <= fetchAddr + 1'b1;
    end
  end
endmodule

// File: rtl/split_fetch_addr.sv
module split_fetch_addr
  import splitscr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic [7:0]       hostWrData,
  output logic [7:0]       hostRdData,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic             pixFetch,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic             inScreen2
);
  addr_t     scr1Pend, scr2Pend, scr1Act, scr2Act, strideAct;
  line_t     splitPend, splitAct, panelAct;
  fetchCmd_t cmd;

  splitscr_regs regs_i (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .idx(hostIdx), .wrData(hostWrData),
    .frameStart(frameStart), .rdData(hostRdData),
    .scr1Pend(scr1Pend), .scr2Pend(scr2Pend), .scr1Act(scr1Act), .scr2Act(scr2Act),
    .strideAct(strideAct), .splitPend(splitPend), .splitAct(splitAct), .panelAct(panelAct)
  );

  splitscr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .pixFetch(pixFetch), .splitPend(splitPend), .splitAct(splitAct),
    .panelAct(panelAct), .cmd(cmd), .inScreen2(inScreen2)
  );

  splitscr_path path_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .scr1Pend(scr1Pend), .scr2Pend(scr2Pend),
    .scr1Act(scr1Act), .scr2Act(scr2Act), .strideAct(strideAct), .fetchAddr(fetchAddr)
  );
endmodule

// File: rtl/splitscr_chk.sv
module splitscr_chk
  import splitscr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] hostIdx,
  input logic [7:0]       hostRdData,
  input logic             frameStart,
  input logic             lineStart,
  input logic             pixFetch,
  input addr_t            fetchAddr,
  input logic             inScreen2,
  input line_t            splitPend,
  input addr_t            scr2Act
);
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixFetch && !frameStart && !lineStart) |=> (fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pixFetch && !frameStart && !lineStart) |=> ($stable(fetchAddr) && $stable(inScreen2))); // R4

  AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && splitPend != '0) |=> !inScreen2); // R3

  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && splitPend == '0) |=> inScreen2); // R8

  AST_S2_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inScreen2) |-> (fetchAddr == scr2Act)); // R6

  AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostIdx == 4'd5 || hostIdx == 4'd9) |-> (hostRdData[7:HI_W] == '0)); // R1
endmodule

bind split_fetch_addr splitscr_chk chk_i (
  .clk(clk), .rstN(rstN), .hostIdx(hostIdx), .hostRdData(hostRdData),
  .frameStart(frameStart), .lineStart(lineStart), .pixFetch(pixFetch),
  .fetchAddr(fetchAddr), .inScreen2(inScreen2), .splitPend(splitPend), .scr2Act(scr2Act)
);

// File: tb/split_fetch_addr_tb.sv
module split_fetch_addr_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostIdx = '0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic        pixFetch = 1'b0;
  logic [15:0] fetchAddr;
  logic        inScreen2;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  split_fetch_addr dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostIdx(hostIdx),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .frameStart(frameStart),
    .lineStart(lineStart), .pixFetch(pixFetch), .fetchAddr(fetchAddr), .inScreen2(inScreen2)
  );

  // reference model state
  logic [7:0]  regMir [0:9];
  logic [15:0] aS1, aS2, aSt;
  int          aSp, aPn;
  logic [15:0] mBase, mAddr;
  int          mLine;
  logic        mS2;

  logic [15:0] qAddr[$];
  logic        qS2[$];
  string       qTag[$];

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item after the edge that follows a strobe
  always @(posedge clk) begin
    #1;
    if (qAddr.size() > 0) begin
      logic [15:0] ea;
      logic        es;
      string       et;
      ea = qAddr.pop_front();
      es = qS2.pop_front();
      et = qTag.pop_front();
      chk({et, " addr"}, int'(fetchAddr), int'(ea));
      chk({et, " region"}, int'(inScreen2), int'(es));
    end
  end

  function automatic logic [15:0] mir16(int lo);
    return {regMir[lo+1], regMir[lo]};
  endfunction
  function automatic int mir10(int lo);
    return int'({regMir[lo+1][1:0], regMir[lo]});
  endfunction

  task automatic push(string tag);
    qAddr.push_back(mAddr);
    qS2.push_back(mS2);
    qTag.push_back(tag);
  endtask

  task automatic hostWr(int idx, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostIdx = 4'(idx); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    regMir[idx] = d;
  endtask

  task automatic hostRd(int idx, int exp, string tag);
    @(negedge clk);
    hostIdx = 4'(idx);
    #1 chk(tag, int'(hostRdData), exp);
  endtask

  task automatic doFrame(string tag);
    aS1 = mir16(0); aS2 = mir16(2); aSt = mir16(6);
    aSp = mir10(4); aPn = mir10(8);
    mLine = 0; mS2 = (aSp == 0);
    mBase = mS2 ? aS2 : aS1; mAddr = mBase;
    @(negedge clk);
    frameStart = 1'b1;
    push(tag);
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic doLine(string tag, bit withPix);
    int nl;
    nl = mLine + 1;
    if (nl == aPn) begin
      mLine = 0; mS2 = (aSp == 0);
      mBase = mS2 ? aS2 : aS1;
    end else begin
      mLine = nl;
      if (nl == aSp && !mS2) begin
        mS2 = 1'b1; mBase = aS2;
      end else begin
        mBase = mBase + aSt;
      end
    end
    mAddr = mBase;
    @(negedge clk);
    lineStart = 1'b1; pixFetch = withPix;
    push(tag);
    @(negedge clk);
    lineStart = 1'b0; pixFetch = 1'b0;
  endtask

  task automatic doPix(string tag);
    mAddr = mAddr + 16'd1;
    @(negedge clk);
    pixFetch = 1'b1;
    push(tag);
    @(negedge clk);
    pixFetch = 1'b0;
  endtask

  task automatic progAll(logic [15:0] s1, logic [15:0] s2, int sp, logic [15:0] st, int pn);
    hostWr(0, s1[7:0]); hostWr(1, s1[15:8]);
    hostWr(2, s2[7:0]); hostWr(3, s2[15:8]);
    hostWr(4, 8'(sp));  hostWr(5, 8'(sp >> 8));
    hostWr(6, st[7:0]); hostWr(7, st[15:8]);
    hostWr(8, 8'(pn));  hostWr(9, 8'(pn >> 8));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) regMir[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    chk("R10 fetchAddr", int'(fetchAddr), 0);
    chk("R10 inScreen2", int'(inScreen2), 0);
    for (int i = 0; i < 10; i++) hostRd(i, 0, "R10 reg");

    // R1: readback; high bits of split/panel MSB read zero
    progAll(16'h1000, 16'h0200, 3, 16'h0040, 6);
    hostWr(5, 8'hFC); // only bits 1:0 stored -> 0
    hostRd(0, 8'h00, "R1 scr1 lo");
    hostRd(1, 8'h10, "R1 scr1 hi");
    hostRd(3, 8'h02, "R1 scr2 hi");
    hostRd(4, 8'h03, "R1 split lo");
    hostRd(5, 8'h00, "R1 split hi masked");
    hostWr(9, 8'hFD); regMir[9] = 8'h01;
    hostRd(9, 8'h01, "R1 panel hi masked");
    hostWr(9, 8'h00);
    hostRd(12, 0, "R1 unused index");

    // R2: nothing visible before frame start
    repeat (2) @(negedge clk);
    chk("R2 addr before frame", int'(fetchAddr), 0);

    // frame 1: lower start below upper start (R9)
    doFrame("R3 frame top");
    doPix("R4 pix1"); doPix("R4 pix2"); doPix("R4 pix3");
    doLine("R5 line1", 0);
    hostWr(0, 8'h00); hostWr(1, 8'h30); // new scr1 pending
    @(negedge clk);
    chk("R2 addr after mid-frame write", int'(fetchAddr), int'(mAddr));
    doLine("R5 line2", 0);
    doLine("R6 R9 split entry", 0);
    doPix("R4 pix in screen2");
    doLine("R6 stride in screen2", 0);
    doLine("R6 line5", 0);
    doLine("R7 wrap", 0);
    doLine("R4 line beats pix", 1);

    // frame 2: split beyond panel height
    hostWr(4, 8'd10);
    doFrame("R7 frame2 top");
    for (int i = 0; i < 8; i++) doLine("R7 no split", 0);

    // frame 3: split count zero
    hostWr(4, 8'd0);
    doFrame("R8 split zero");
    doLine("R8 line1", 0);
    doPix("R8 pix");
    doLine("R8 line2", 0);

    // frame 4: identical start addresses
    progAll(16'h0500, 16'h0500, 2, 16'h0010, 5);
    doFrame("R9 same addr top");
    doLine("R9 line1", 0);
    doLine("R9 split same addr", 0);
    doLine("R9 line3", 0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule